// File: doc/BRIEF.md
# Grey-to-Binary Converter with Error Diffusion

This block turns a stream of 6-bit grey pixels into one output bit per pixel, suitable for a bilevel transmission path. Each incoming code first passes through a 64-entry tone-curve table that software loads. The remapped value is then binarized in one of two ways. Threshold mode compares the upper five bits against a programmable level. Diffusion mode spreads each pixel's quantization error to its neighbours, so areas of intermediate grey come out as dot patterns whose density follows the grey level.

Pixels arrive with a valid strobe and three markers: line start, line end and page start. Errors headed for the next line are kept in an internal one-line buffer of signed values. A page start makes the first line of the page ignore whatever that buffer holds. Configuration uses a plain write port. Addresses 0 to 63 select table entries, address 64 holds the threshold and address 65 holds the mode.

Top module: `binarizer_ed`

## Requirements
- R1: Every pixel taken with `pix_valid_i` high produces exactly one output bit with `bit_valid_o` high two clock edges later, in input order, with the line start, line end and page start markers delayed by the same amount.
- R2: After reset the tone table is the identity mapping. A write to address a (0 to 63) sets the entry for code a to `cfg_wdata_i`, and every later pixel is binarized using its table value instead of its raw code.
- R3: A configuration write is accepted only if `pix_valid_i` is low in the write cycle and was also low in the cycle before. Otherwise the write has no effect on the table, the threshold or the mode.
- R4: In threshold mode (address 65, bit 0 = 0, the reset mode), the output is 1 exactly when bits 5:1 of the table value are greater than or equal to the 5-bit level written at address 64 (data bits 4:0). The level resets to 16.
- R5: In diffusion mode (address 65, bit 0 = 1), the working level is the table value plus the error carried from the left neighbour plus the error stored for this column by the previous line. The output is 1 when the level is at least 32. The error is the level minus 63 when the output is 1, and the level itself when the output is 0.
- R6: The error is shared as floor(e*7/16) to the next pixel on the same line, and as floor(e*3/16), floor(e*5/16) and floor(e*1/16) to the columns left-below, below and right-below on the next line. Each floor rounds toward minus infinity. Stored values saturate to the range -128 to 127.
- R7: No error crosses a line edge. The first pixel of a line gets no carry from the left. Shares aimed at column -1, or at the column past a line's last pixel, are dropped.
- R8: The first line after a page start uses zero as the stored error for every column, whatever the buffer holds.
- R9: In threshold mode all diffused errors are zero. A diffusion-mode line that follows a threshold-mode line in the same page behaves as if it had no stored error.
- R10: Input stream rules: a page start comes only with a line start, every line ends with a line end before the next line start, and a line has between 3 and LINE_MAX pixels (default 2048). Lines may follow each other with no idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 7 | Write address: 0-63 table, 64 threshold, 65 mode |
| cfg_wdata_i | input | 6 | Write data |
| pix_valid_i | input | 1 | Pixel strobe |
| pix_sol_i | input | 1 | First pixel of a line |
| pix_eol_i | input | 1 | Last pixel of a line |
| pix_sop_i | input | 1 | First pixel of a page |
| pix_data_i | input | 6 | Grey code |
| bit_valid_o | output | 1 | Output bit strobe |
| bit_o | output | 1 | Binary pixel, 1 = white |
| bit_sol_o | output | 1 | Line start marker of this bit |
| bit_eol_o | output | 1 | Line end marker of this bit |
| bit_sop_o | output | 1 | Page start marker of this bit |

## Verification
The assertions take R10 for granted. Every line is at least three pixels long and closes with a line end, and a page start always comes with a line start. These rules keep the buffer's end-of-line write from landing on a column the next line is reading in the same cycle. The stimulus keeps to them: random line lengths are drawn from 3 upward, one line runs the full 2048 pixels, and lines are sent both back to back and with random idle gaps. Configuration writes are normally issued only after the stream has gone idle. The one exception is a few writes placed on purpose during or right after a pixel, which the reference model treats as ignored.

// File: rtl/binarizer_ed_pkg.sv
package binarizer_ed_pkg;
  typedef enum logic {
    MODE_SLICE   = 1'b0,
    MODE_DIFFUSE = 1'b1
  } bin_mode_e;
endpackage

// File: rtl/binarizer_ed_gamma.sv
module binarizer_ed_gamma #(
  parameter int unsigned PIX_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [PIX_W-1:0] waddr_i,
  input  logic [PIX_W-1:0] wdata_i,
  input  logic [PIX_W-1:0] raddr_i,
  output logic [PIX_W-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << PIX_W;

  logic [PIX_W-1:0] tab_q [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              tab_q[e] <= PIX_W'(e);
      else if (we_i && waddr_i == PIX_W'(e))    tab_q[e] <= wdata_i;
    end
  end

  assign rdata_o = tab_q[raddr_i];
endmodule

// File: rtl/binarizer_ed_errbuf.sv
module binarizer_ed_errbuf #(
  parameter int unsigned DEPTH  = 2048,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
  input  logic                     clk_i,
  input  logic                     re_i,
  input  logic [ADDR_W-1:0]        raddr_i,
  output logic signed [DATA_W-1:0] rdata_o,
  input  logic                     we_i,
  input  logic [ADDR_W-1:0]        waddr_i,
  input  logic signed [DATA_W-1:0] wdata_i
);
  logic signed [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
    if (re_i) rdata_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/binarizer_ed_core.sv
module binarizer_ed_core import binarizer_ed_pkg::*; #(
  parameter int unsigned PIX_W = 6,
  parameter int unsigned ERR_W = 8,
  parameter int unsigned ACC_W = 12,
  parameter int unsigned X_W   = 11,
  localparam int unsigned SLICE_W = PIX_W - 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    valid_i,
  input  logic [PIX_W-1:0]        gray_i,
  input  logic signed [ERR_W-1:0] line_err_i,
  input  logic                    sol_i,
  input  logic                    eol_i,
  input  logic                    sop_i,
  input  logic [X_W-1:0]          x_i,
  input  bin_mode_e               mode_i,
  input  logic [SLICE_W-1:0]      slice_i,
  output logic                    bit_valid_o,
  output logic                    bit_o,
  output logic                    bit_sol_o,
  output logic                    bit_eol_o,
  output logic                    bit_sop_o,
  output logic                    main_we_o,
  output logic [X_W-1:0]          main_addr_o,
  output logic signed [ERR_W-1:0] main_data_o,
  output logic                    flush_we_o,
  output logic [X_W-1:0]          flush_addr_o,
  output logic signed [ERR_W-1:0] flush_data_o
);
  localparam int unsigned PROD_W = ACC_W + 4;
  localparam logic signed [ACC_W-1:0] HALF_S = ACC_W'(1 << (PIX_W - 1));
  localparam logic signed [ACC_W-1:0] FULL_S = ACC_W'((1 << PIX_W) - 1);
  localparam logic signed [ACC_W-1:0] EMAX_S = ACC_W'((1 << (ERR_W - 1)) - 1);
  localparam logic signed [ACC_W-1:0] EMIN_S = -EMAX_S - ACC_W'(1);
  localparam logic signed [PROD_W-1:0] W7 = PROD_W'(7);
  localparam logic signed [PROD_W-1:0] W5 = PROD_W'(5);
  localparam logic signed [PROD_W-1:0] W3 = PROD_W'(3);
  localparam logic signed [PROD_W-1:0] W1 = PROD_W'(1);

  function automatic logic signed [ERR_W-1:0] sat(input logic signed [ACC_W-1:0] v);
    if (v > EMAX_S)      return EMAX_S[ERR_W-1:0];
    else if (v < EMIN_S) return EMIN_S[ERR_W-1:0];
    else                 return v[ERR_W-1:0];
  endfunction

  function automatic logic signed [ACC_W-1:0] share(input logic signed [PROD_W-1:0] e,
                                                    input logic signed [PROD_W-1:0] w);
    logic signed [PROD_W-1:0] p;
    p = (e * w) >>> 4;
    return p[ACC_W-1:0];
  endfunction

  logic signed [ACC_W-1:0] carry_q, pend_a_q, pend_b_q;
  logic signed [ACC_W-1:0] carry_in, pend_b_in, level, err;
  logic signed [ACC_W-1:0] sh7, sh5, sh3, sh1, pend_a_nx, main_sum;
  logic signed [PROD_W-1:0] err_x;
  logic out_bit;

  always_comb begin
    carry_in  = sol_i ? '0 : carry_q;
    pend_b_in = sol_i ? '0 : pend_b_q;
    level     = ACC_W'($signed({1'b0, gray_i})) + carry_in + ACC_W'(line_err_i);
    if (mode_i == MODE_SLICE) begin
      out_bit = gray_i[PIX_W-1:1] >= slice_i;
      err     = '0;
    end else begin
      out_bit = level >= HALF_S;
      err     = out_bit ? level - FULL_S : level;
    end
    err_x     = PROD_W'(err);
    sh7       = share(err_x, W7);
    sh5       = share(err_x, W5);
    sh3       = share(err_x, W3);
    sh1       = share(err_x, W1);
    main_sum  = pend_a_q + sh3;
    pend_a_nx = pend_b_in + sh5;
  end

  // left-below tap: column x-1 is complete once pixel x is known
  assign main_we_o   = valid_i && !sol_i;
  assign main_addr_o = x_i - X_W'(1);
  assign main_data_o = sat(main_sum);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      carry_q      <= '0;
      pend_a_q     <= '0;
      pend_b_q     <= '0;
      flush_we_o   <= 1'b0;
      flush_addr_o <= '0;
      flush_data_o <= '0;
      bit_valid_o  <= 1'b0;
      bit_o        <= 1'b0;
      bit_sol_o    <= 1'b0;
      bit_eol_o    <= 1'b0;
      bit_sop_o    <= 1'b0;
    end else begin
      flush_we_o  <= valid_i && eol_i;
      bit_valid_o <= valid_i;
      bit_o       <= valid_i && out_bit;
      bit_sol_o   <= valid_i && sol_i;
      bit_eol_o   <= valid_i && eol_i;
      bit_sop_o   <= valid_i && sop_i;
      if (valid_i) begin
        carry_q      <= eol_i ? '0 : sh7;
        pend_a_q     <= pend_a_nx;
        pend_b_q     <= sh1;
        flush_addr_o <= x_i;
        flush_data_o <= sat(pend_a_nx);
      end
    end
  end
endmodule

// File: rtl/binarizer_ed.sv
module binarizer_ed import binarizer_ed_pkg::*; #(
  parameter int unsigned PIX_W    = 6,
  parameter int unsigned LINE_MAX = 2048,
  parameter int unsigned ERR_W    = 8,
  parameter int unsigned ACC_W    = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [PIX_W:0]   cfg_addr_i,
  input  logic [PIX_W-1:0] cfg_wdata_i,
  input  logic             pix_valid_i,
  input  logic             pix_sol_i,
  input  logic             pix_eol_i,
  input  logic             pix_sop_i,
  input  logic [PIX_W-1:0] pix_data_i,
  output logic             bit_valid_o,
  output logic             bit_o,
  output logic             bit_sol_o,
  output logic             bit_eol_o,
  output logic             bit_sop_o
);
  localparam int unsigned X_W     = $clog2(LINE_MAX);
  localparam int unsigned SLICE_W = PIX_W - 1;
  localparam logic [PIX_W:0] ADDR_SLICE = (PIX_W+1)'(1 << PIX_W);
  localparam logic [PIX_W:0] ADDR_MODE  = ADDR_SLICE + (PIX_W+1)'(1);

  // configuration
  bin_mode_e          mode_q;
  logic [SLICE_W-1:0] slice_q;
  logic               s1_valid;
  logic               cfg_ok, gam_we;

  assign cfg_ok = cfg_we_i && !pix_valid_i && !s1_valid;
  assign gam_we = cfg_ok && !cfg_addr_i[PIX_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= MODE_SLICE;
      slice_q <= SLICE_W'(1 << (SLICE_W - 1));
    end else if (cfg_ok) begin
      if (cfg_addr_i == ADDR_SLICE) slice_q <= cfg_wdata_i[SLICE_W-1:0];
      if (cfg_addr_i == ADDR_MODE)  mode_q  <= bin_mode_e'(cfg_wdata_i[0]);
    end
  end

  logic [PIX_W-1:0] gam_rdata;

  binarizer_ed_gamma #(.PIX_W(PIX_W)) u_gamma (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (gam_we),
    .waddr_i (cfg_addr_i[PIX_W-1:0]),
    .wdata_i (cfg_wdata_i),
    .raddr_i (pix_data_i),
    .rdata_o (gam_rdata)
  );

  // stage 0: column count, page tracking, buffer read
  logic [X_W-1:0]   x_q, x_cur, s1_x;
  logic             first_q, first_cur, s1_first;
  logic [PIX_W-1:0] s1_gray;
  logic             s1_sol, s1_eol, s1_sop;

  assign x_cur     = pix_sol_i ? '0 : x_q + X_W'(1);
  assign first_cur = pix_sop_i ? 1'b1 : (pix_sol_i ? 1'b0 : first_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_q      <= '0;
      first_q  <= 1'b0;
      s1_valid <= 1'b0;
      s1_gray  <= '0;
      s1_sol   <= 1'b0;
      s1_eol   <= 1'b0;
      s1_sop   <= 1'b0;
      s1_x     <= '0;
      s1_first <= 1'b0;
    end else begin
      s1_valid <= pix_valid_i;
      if (pix_valid_i) begin
        x_q      <= x_cur;
        first_q  <= first_cur;
        s1_gray  <= gam_rdata;
        s1_sol   <= pix_sol_i;
        s1_eol   <= pix_eol_i;
        s1_sop   <= pix_sop_i;
        s1_x     <= x_cur;
        s1_first <= first_cur;
      end
    end
  end

  logic signed [ERR_W-1:0] buf_rdata, line_err;
  logic                    main_we, flush_we, buf_we;
  logic [X_W-1:0]          main_addr, flush_addr, buf_waddr;
  logic signed [ERR_W-1:0] main_data, flush_data, buf_wdata;

  assign buf_we    = main_we || flush_we;
  assign buf_waddr = flush_we ? flush_addr : main_addr;
  assign buf_wdata = flush_we ? flush_data : main_data;

  binarizer_ed_errbuf #(.DEPTH(LINE_MAX), .DATA_W(ERR_W)) u_errbuf (
    .clk_i   (clk_i),
    .re_i    (pix_valid_i),
    .raddr_i (x_cur),
    .rdata_o (buf_rdata),
    .we_i    (buf_we),
    .waddr_i (buf_waddr),
    .wdata_i (buf_wdata)
  );

  // first line of a page sees a cleared buffer
  assign line_err = s1_first ? '0 : buf_rdata;

  // stage 1: binarize and diffuse
  binarizer_ed_core #(
    .PIX_W (PIX_W),
    .ERR_W (ERR_W),
    .ACC_W (ACC_W),
    .X_W   (X_W)
  ) u_core (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .valid_i      (s1_valid),
    .gray_i       (s1_gray),
    .line_err_i   (line_err),
    .sol_i        (s1_sol),
    .eol_i        (s1_eol),
    .sop_i        (s1_sop),
    .x_i          (s1_x),
    .mode_i       (mode_q),
    .slice_i      (slice_q),
    .bit_valid_o  (bit_valid_o),
    .bit_o        (bit_o),
    .bit_sol_o    (bit_sol_o),
    .bit_eol_o    (bit_eol_o),
    .bit_sop_o    (bit_sop_o),
    .main_we_o    (main_we),
    .main_addr_o  (main_addr),
    .main_data_o  (main_data),
    .flush_we_o   (flush_we),
    .flush_addr_o (flush_addr),
    .flush_data_o (flush_data)
  );
endmodule

// File: rtl/binarizer_ed_chk.sv
module binarizer_ed_chk #(
  parameter int unsigned SLICE_W = 5
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               pix_valid_i,
  input logic               pix_sol_i,
  input logic               pix_eol_i,
  input logic               pix_sop_i,
  input logic               cfg_we_i,
  input logic               bit_valid_o,
  input logic               bit_sol_o,
  input logic               bit_eol_o,
  input logic               bit_sop_o,
  input logic               main_we,
  input logic               flush_we,
  input logic               mode_q,
  input logic [SLICE_W-1:0] slice_q
);
  logic [1:0] len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       len_q <= '0;
    else if (pix_valid_i && pix_sol_i) len_q <= 2'd1;
    else if (pix_valid_i && len_q != 2'd3) len_q <= len_q + 2'd1;
  end

  a_r1_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_valid_i |-> ##2 bit_valid_o);

  a_r1_markers: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_valid_i && pix_sol_i) |-> ##2 (bit_sol_o && (bit_sop_o == $past(pix_sop_i, 2))));

  a_r1_eol: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_valid_i && pix_eol_i) |-> ##2 bit_eol_o);

  a_r3_busy_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && pix_valid_i) |=> ($stable(mode_q) && $stable(slice_q)));

  a_r7_one_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(main_we && flush_we));

  a_r10_sop_sol: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_valid_i && pix_sop_i) |-> pix_sol_i);

  a_r10_min_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_valid_i && pix_eol_i) |-> (!pix_sol_i && len_q >= 2'd2));
endmodule

bind binarizer_ed binarizer_ed_chk #(.SLICE_W(SLICE_W)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .pix_valid_i (pix_valid_i),
  .pix_sol_i   (pix_sol_i),
  .pix_eol_i   (pix_eol_i),
  .pix_sop_i   (pix_sop_i),
  .cfg_we_i    (cfg_we_i),
  .bit_valid_o (bit_valid_o),
  .bit_sol_o   (bit_sol_o),
  .bit_eol_o   (bit_eol_o),
  .bit_sop_o   (bit_sop_o),
  .main_we     (main_we),
  .flush_we    (flush_we),
  .mode_q      (mode_q),
  .slice_q     (slice_q)
);

// File: tb/binarizer_ed_tb_top.sv
module binarizer_ed_tb_top;
  localparam int LINE_MAX = 2048;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cfg_we_i = 1'b0;
  logic [6:0] cfg_addr_i = '0;
  logic [5:0] cfg_wdata_i = '0;
  logic       pix_valid_i = 1'b0, pix_sol_i = 1'b0, pix_eol_i = 1'b0, pix_sop_i = 1'b0;
  logic [5:0] pix_data_i = '0;
  logic       bit_valid_o, bit_o, bit_sol_o, bit_eol_o, bit_sop_o;

  always #2 clk_i = ~clk_i;

  binarizer_ed dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .cfg_we_i(cfg_we_i), .cfg_addr_i(cfg_addr_i), .cfg_wdata_i(cfg_wdata_i),
    .pix_valid_i(pix_valid_i), .pix_sol_i(pix_sol_i), .pix_eol_i(pix_eol_i),
    .pix_sop_i(pix_sop_i), .pix_data_i(pix_data_i),
    .bit_valid_o(bit_valid_o), .bit_o(bit_o), .bit_sol_o(bit_sol_o),
    .bit_eol_o(bit_eol_o), .bit_sop_o(bit_sop_o)
  );

  int checks = 0, errors = 0, cyc = 0, ones = 0;
  string cur_tag = "R1";

  // reference model state
  int gtab[64];
  int mbuf[LINE_MAX];
  int m_slice = 16, m_mode = 0, m_carry = 0, m_pa = 0, m_pb = 0, m_x = 0;
  bit m_first = 0, last_v = 0;

  logic [3:0] exp_q[$];
  int         exp_cyc[$];
  string      exp_tag[$];

  always @(posedge clk_i) cyc <= cyc + 1;

  function automatic int fl16(int e, int w);
    return (e * w) >>> 4;
  endfunction

  function automatic int sat8(int v);
    if (v > 127) return 127;
    if (v < -128) return -128;
    return v;
  endfunction

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic void model_cfg(int addr, int data);
    if (addr < 64) gtab[addr] = data;
    else if (addr == 64) m_slice = data & 31;
    else if (addr == 65) m_mode = data & 1;
  endfunction

  function automatic bit model_px(int p, bit sol, bit eol, bit sop);
    int g, eb, cin, v, err, pa_n;
    bit b;
    g = gtab[p];
    if (sop) m_first = 1; else if (sol) m_first = 0;
    m_x = sol ? 0 : m_x + 1;
    eb = m_first ? 0 : mbuf[m_x];
    cin = sol ? 0 : m_carry;
    if (m_mode == 0) begin
      b = (g >> 1) >= m_slice; err = 0;
    end else begin
      v = g + cin + eb; b = v >= 32; err = b ? v - 63 : v;
    end
    if (!sol) mbuf[m_x - 1] = sat8(m_pa + fl16(err, 3));
    pa_n = (sol ? 0 : m_pb) + fl16(err, 5);
    m_pb = fl16(err, 1);
    m_pa = pa_n;
    m_carry = eol ? 0 : fl16(err, 7);
    if (eol) mbuf[m_x] = sat8(m_pa);
    return b;
  endfunction

  task automatic drive(bit v, int p, bit sol, bit eol, bit sop, bit we, int addr, int data);
    bit b;
    @(negedge clk_i);
    pix_valid_i = v; pix_data_i = 6'(p); pix_sol_i = v & sol; pix_eol_i = v & eol;
    pix_sop_i = v & sop;
    cfg_we_i = we; cfg_addr_i = 7'(addr); cfg_wdata_i = 6'(data);
    if (v) begin
      b = model_px(p, sol, eol, sop);
      exp_q.push_back({b, sol, eol, sop});
      exp_cyc.push_back(cyc + 2);
      exp_tag.push_back(cur_tag);
    end
    if (we && !v && !last_v) model_cfg(addr, data);
    last_v = v;
  endtask

  task automatic cfg_wr(int addr, int data);
    drive(0, 0, 0, 0, 0, 1, addr, data);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) drive(0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  // kind: 0 constant, 1 ramp, 2 random
  task automatic line(int len, bit sop, int kind, int base);
    for (int i = 0; i < len; i++) begin
      int p;
      p = (kind == 0) ? base : (kind == 1) ? ((base + i) % 64) : int'($urandom_range(63, 0));
      drive(1, p, i == 0, i == len - 1, sop && i == 0, 0, 0, 0);
    end
  endtask

  // output monitor, away from the active edge
  always @(negedge clk_i) begin
    if (rst_ni && bit_valid_o) begin
      if (exp_q.size() == 0) begin
        check(0, "R1", "unexpected output bit", 1, 0);
      end else begin
        logic [3:0] e;
        int ec;
        string t;
        e = exp_q.pop_front(); ec = exp_cyc.pop_front(); t = exp_tag.pop_front();
        check(bit_o == e[3], t, "output bit", int'(bit_o), int'(e[3]));
        check({bit_sol_o, bit_eol_o, bit_sop_o} == e[2:0], "R1", "markers",
              int'({bit_sol_o, bit_eol_o, bit_sop_o}), int'(e[2:0]));
        check(cyc == ec, "R1", "latency cycle", cyc, ec);
        if (bit_o) ones++;
      end
    end
  end

  initial begin
    #600000;
    errors++;
    $display("FAIL R1 watchdog expired: actual 0 expected 1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0b1d));
    for (int i = 0; i < 64; i++) gtab[i] = i;
    for (int i = 0; i < LINE_MAX; i++) mbuf[i] = 0;
    repeat (3) @(negedge clk_i);
    check(bit_valid_o == 0 && bit_o == 0 && bit_sol_o == 0, "R1", "reset outputs",
          int'(bit_valid_o), 0);
    rst_ni = 1'b1;
    idle(2);

    // full-length line, identity table, reset threshold 16 (R2 R4 R10)
    cur_tag = "R10";
    line(LINE_MAX, 1, 1, 0);
    idle(3);

    // ramp over all codes with identity table (R2) and threshold sweep (R4)
    cur_tag = "R2";
    line(64, 1, 1, 0);
    idle(3);
    cur_tag = "R4";
    cfg_wr(64, 0);  line(64, 0, 1, 0); idle(3);
    cfg_wr(64, 31); line(64, 0, 1, 0); idle(3);
    cfg_wr(64, 10); line(64, 0, 1, 5); idle(3);

    // inverted table (R2)
    cur_tag = "R2";
    for (int i = 0; i < 64; i++) cfg_wr(i, 63 - i);
    line(64, 0, 1, 0);
    idle(3);

    // writes during or just after a pixel are ignored (R3)
    cur_tag = "R3";
    drive(1, 5, 1, 0, 1, 1, 5, 0);
    drive(1, 6, 0, 0, 0, 1, 64, 31);
    drive(1, 7, 0, 1, 0, 0, 0, 0);
    drive(0, 0, 0, 0, 0, 1, 65, 1);
    idle(2);
    line(8, 0, 1, 2);
    idle(3);
    for (int i = 0; i < 64; i++) cfg_wr(i, i);

    // diffusion: flat levels (R5 R6 R7 R8)
    cfg_wr(65, 1);
    cur_tag = "R5";
    line(40, 1, 0, 63); line(40, 0, 0, 0);
    idle(2);
    cur_tag = "R6";
    ones = 0;
    for (int l = 0; l < 8; l++) line(60, l == 0, 0, 21);
    idle(4);
    check(ones >= 140 && ones <= 180, "R5", "gradation ones for level 21", ones, 160);
    cur_tag = "R7";
    line(3, 1, 2, 0); line(3, 0, 2, 0); line(5, 0, 1, 30); line(3, 0, 0, 40);
    idle(3);

    // page start discards stored error (R8)
    cur_tag = "R8";
    line(30, 0, 0, 31); line(30, 1, 0, 33); line(30, 0, 0, 33);
    idle(3);

    // threshold line then diffusion in same page (R9)
    cur_tag = "R9";
    line(20, 0, 0, 45);
    cfg_wr(65, 0); cfg_wr(64, 16);
    line(20, 0, 2, 0);
    cfg_wr(65, 1);
    line(20, 0, 0, 17);
    idle(3);

    // random pages, tables, modes, lengths and gaps (R6 R10)
    cur_tag = "R6";
    for (int k = 0; k < 40; k++) begin
      if (k % 10 == 0) begin
        for (int i = 0; i < 64; i++) cfg_wr(i, int'($urandom_range(63, 0)));
        cfg_wr(64, int'($urandom_range(31, 0)));
        cfg_wr(65, int'($urandom_range(1, 0)));
      end
      line(int'($urandom_range(48, 3)), (k % 7) == 0, 2, 0);
      if ($urandom_range(1, 0) == 1) idle(int'($urandom_range(3, 1)));
    end
    idle(5);

    check(exp_q.size() == 0, "R1", "pending bits after drain", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule